// File: doc/BRIEF.md
# Serial EEPROM configuration autoloader

After reset this block reads a fixed-size configuration image out of a serial EEPROM that uses a three-wire read protocol. It holds the EEPROM clock pin low as an output. During reset it reads the level on that pin, which an external strap sets, to learn whether a memory is fitted. When a memory is fitted, the block waits a fixed delay after reset and then issues one read command per 16-bit word. It keeps a running 8-bit sum of every byte it receives.

The first 16 bytes are station-address bytes and are written into their registers as soon as they arrive. The remaining bytes are held in a temporary RAM. They are copied into the configuration registers only if the 8-bit sum of the whole image comes to FFh. When the sum is wrong, the configuration registers go back to their defaults and the address bytes stay as they were loaded.

While any load runs, every host access request on the access port is answered with a retry. A host can start a fresh load with a one-cycle reload request. A registered byte read port shows what is currently committed.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: The level of `ee_sk_sense` in the last cycle with `rst` high is taken as the presence strap. If it is 0, `ee_cs` never rises, and the load ends with a `done` pulse, `cfg_valid`=0 and `reload_bit`=0. Configuration bytes 16..35 then read as their defaults, where the default of byte address a is a XOR C3h.
- R2: Each word read holds `ee_cs` high and sends nine bits on `ee_di`, MSB first: 1, 1, 0, then the 6-bit word address. It then captures 16 data bits from `ee_do`, MSB first. Words 0..17 are read in ascending order. The low byte of word w lands at byte address 2w and the high byte at 2w+1.
- R3: Each low and each high phase of `ee_sk` lasts exactly HALF_DIV clocks. `ee_sk` is only high while `ee_cs` is high, and `ee_di` does not change while `ee_sk` is high. Between two words, `ee_cs` stays low for at least 2*HALF_DIV clocks.
- R4: If the 8-bit sum of all 36 bytes is FFh, then `cfg_valid` is 1 after the load and bytes 0..35 read back the loaded image.
- R5: If the sum is not FFh, then `cfg_valid` is 0 after the load, bytes 16..35 read as their defaults, and bytes 0..15 read the newly loaded values.
- R6: While a load is running, bytes 16..35 keep the values they had before the load, and `cfg_valid` does not change.
- R7: A `reload_req` high in an idle cycle makes `reload_bit` and `busy` 1 in the next cycle and starts a new load. `reload_bit` stays 1 until that load's `done`. A `reload_req` while `busy` is 1 is ignored.
- R8: An `acc_req` sampled while `busy` is 1 gets `acc_sel`=1, `acc_stop`=1 and `acc_rdy`=0 in the next cycle. Sampled while `busy` is 0, it gets `acc_sel`=1, `acc_rdy`=1 and `acc_stop`=0. With no request, all three outputs are 0.
- R9: `done` is a one-cycle pulse in the first cycle with `busy`=0 after a load. `cfg_valid` takes its new value in that same cycle.
- R10: While `rst` is high, `busy`=1, `reload_bit`=1, `cfg_valid`=0, `done`=0 and `ee_cs`=0. After reset releases, `ee_cs` stays low for at least START_DLY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ee_sk_sense | input | 1 | Level of the EEPROM clock pin, sampled as the presence strap during reset |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| reload_req | input | 1 | One-cycle host request for a fresh load |
| reload_bit | output | 1 | Reload in progress |
| cfg_valid | output | 1 | Last load passed its checksum |
| busy | output | 1 | Load running, accesses are retried |
| done | output | 1 | One-cycle pulse when a load completes or aborts |
| acc_req | input | 1 | Host access request |
| acc_sel | output | 1 | Access claimed |
| acc_stop | output | 1 | Retry response |
| acc_rdy | output | 1 | Normal completion response |
| rd_addr | input | 6 | Byte address for the read port |
| rd_data | output | 8 | Registered byte at `rd_addr` |

## Verification
The end of a load and fresh host activity can meet in one cycle. In the cycle where `done` is observed, the bench raises `reload_req` and `acc_req` together. It then expects the access to be claimed normally, because `busy` was already 0. It also expects `busy` and `reload_bit` to be high again one cycle later, and the following load is checked frame by frame against the queued word addresses.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DELAY, S_ISSUE, S_WAIT, S_CHECK, S_COMMIT, S_FINISH
  } ldr_state_t;

  // reset value of a configuration byte at byte address a
  function automatic logic [7:0] cfg_default(input int unsigned a);
    return 8'(a) ^ 8'hC3;
  endfunction
endpackage

// File: rtl/ldr_tick.sv
module ldr_tick #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ldr_mw_read.sv
module ldr_mw_read #(
  parameter int AW        = 6,
  parameter int GAP_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          go,
  input  logic [AW-1:0] addr,
  input  logic          ee_do,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  output logic [15:0]   word,
  output logic          wdone
);
  localparam int CMD_W = 3 + AW;
  localparam int TOT   = CMD_W + 16;
  localparam int BW    = $clog2(TOT + 1);
  localparam int GW    = $clog2(GAP_TICKS + 1);

  typedef enum logic [1:0] {M_IDLE, M_RUN, M_GAP} mw_t;
  mw_t            st;
  logic [CMD_W-1:0] sh;
  logic [BW-1:0]  bitn;
  logic [GW-1:0]  gapn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= M_IDLE; ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
      sh <= '0; bitn <= '0; gapn <= '0; word <= '0; wdone <= 1'b0;
    end else begin
      wdone <= 1'b0;
      case (st)
        M_IDLE: if (go) begin
          sh    <= CMD_W'({3'b110, addr} << 1);
          ee_di <= 1'b1;
          ee_cs <= 1'b1;
          ee_sk <= 1'b0;
          bitn  <= '0;
          st    <= M_RUN;
        end
        M_RUN: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
            if (bitn >= BW'(CMD_W)) word <= {word[14:0], ee_do};
          end else begin
            ee_sk <= 1'b0;
            if (bitn == BW'(TOT - 1)) begin
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
              gapn  <= '0;
              st    <= M_GAP;
            end else begin
              bitn  <= bitn + 1'b1;
              ee_di <= sh[CMD_W-1];
              sh    <= sh << 1;
            end
          end
        end
        M_GAP: if (tick) begin
          if (gapn == GW'(GAP_TICKS - 1)) begin
            wdone <= 1'b1;
            st    <= M_IDLE;
          end else gapn <= gapn + 1'b1;
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R3
  sk_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);
  // R3
  di_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ee_sk && $past(ee_sk) |-> $stable(ee_di));
endmodule

// File: rtl/ldr_store.sv
module ldr_store
  import ldr_pkg::*;
#(
  parameter int NW  = 18,
  parameter int NPW = 8,
  parameter int AW  = 6,
  parameter int IW  = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [15:0]   wr_word,
  input  logic          commit_go,
  output logic          commit_done,
  input  logic          dflt_go,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int NCW = NW - NPW;
  localparam int RIW = $clog2(NCW);
  localparam int CPW = $clog2(NCW + 1);
  localparam int NPB = 2 * NPW;
  localparam int PIW = $clog2(NPB);
  localparam int NCB = 2 * NCW;
  localparam int CFW = $clog2(NCB);
  localparam int NB  = 2 * NW;

  logic [15:0]    tmp_ram [NCW];
  logic [15:0]    ram_q;
  logic [7:0]     prom [NPB];
  logic [7:0]     cfg [NCB];
  logic [CPW-1:0] cptr;
  logic           run, rd_v;
  logic [RIW-1:0] vidx;
  logic [RIW-1:0] ram_wa;

  assign ram_wa = RIW'(wr_idx - IW'(NPW));

  // staging RAM, one write port and one registered read port
  always_ff @(posedge clk) begin
    if (wr_en && wr_idx >= IW'(NPW)) tmp_ram[ram_wa] <= wr_word;
    ram_q <= tmp_ram[cptr[RIW-1:0]];
  end

  // address bytes go straight in, with no checksum gate
  always_ff @(posedge clk) begin
    if (wr_en && wr_idx < IW'(NPW)) begin
      prom[{wr_idx[PIW-2:0], 1'b0}] <= wr_word[7:0];
      prom[{wr_idx[PIW-2:0], 1'b1}] <= wr_word[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; cptr <= '0; rd_v <= 1'b0; vidx <= '0; commit_done <= 1'b0;
    end else begin
      commit_done <= 1'b0;
      rd_v        <= 1'b0;
      if (commit_go) begin
        run  <= 1'b1;
        cptr <= '0;
      end else if (run) begin
        if (cptr == CPW'(NCW)) begin
          run         <= 1'b0;
          commit_done <= 1'b1;
        end else begin
          rd_v <= 1'b1;
          vidx <= cptr[RIW-1:0];
          cptr <= cptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || dflt_go) begin
      for (int i = 0; i < NCB; i++) cfg[i] <= cfg_default(NPB + i);
    end else if (rd_v) begin
      cfg[{vidx, 1'b0}] <= ram_q[7:0];
      cfg[{vidx, 1'b1}] <= ram_q[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          rd_data <= '0;
    else if (rd_addr < AW'(NPB))      rd_data <= prom[rd_addr[PIW-1:0]];
    else if (rd_addr < AW'(NB))       rd_data <= cfg[CFW'(rd_addr - AW'(NPB))];
    else                              rd_data <= '0;
  end

  // R6
  commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rd_v |-> !dflt_go);
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import ldr_pkg::*;
#(
  parameter int HALF_DIV    = 50,
  parameter int START_DLY   = 16,
  parameter int GAP_TICKS   = 2,
  parameter int NWORDS      = 18,
  parameter int NPROM_WORDS = 8,
  parameter int AW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ee_sk_sense,
  input  logic          ee_do,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          reload_req,
  output logic          reload_bit,
  output logic          cfg_valid,
  output logic          busy,
  output logic          done,
  input  logic          acc_req,
  output logic          acc_sel,
  output logic          acc_stop,
  output logic          acc_rdy,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int IW = $clog2(NWORDS);
  localparam int DW = $clog2(START_DLY + 1);

  ldr_state_t    state;
  logic [IW-1:0] widx;
  logic [DW-1:0] dcnt;
  logic [7:0]    sum;
  logic          strap_q, pass_q;
  logic          tick, mw_go, wdone, commit_go, commit_done, dflt_go, dly_end;
  logic [15:0]   word;

  assign dly_end   = (state == S_DELAY) && (dcnt == DW'(START_DLY - 1));
  assign mw_go     = (state == S_ISSUE);
  assign commit_go = (state == S_CHECK) && (sum == 8'hFF);
  assign dflt_go   = (dly_end && !strap_q) || ((state == S_CHECK) && (sum != 8'hFF));

  ldr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(mw_go), .tick(tick));

  ldr_mw_read #(.AW(AW), .GAP_TICKS(GAP_TICKS)) u_mw (
    .clk(clk), .rst(rst), .tick(tick), .go(mw_go), .addr(AW'(widx)),
    .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .word(word), .wdone(wdone));

  ldr_store #(.NW(NWORDS), .NPW(NPROM_WORDS), .AW(AW), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wdone && state == S_WAIT), .wr_idx(widx),
    .wr_word(word), .commit_go(commit_go), .commit_done(commit_done),
    .dflt_go(dflt_go), .rd_addr(rd_addr), .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_DELAY; dcnt <= '0; widx <= '0; sum <= '0;
      reload_bit <= 1'b1; cfg_valid <= 1'b0; busy <= 1'b1; done <= 1'b0;
      strap_q <= ee_sk_sense; pass_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (reload_req) begin
          state <= S_DELAY; dcnt <= '0; reload_bit <= 1'b1; busy <= 1'b1;
        end
        S_DELAY: begin
          dcnt <= dcnt + 1'b1;
          if (dly_end) begin
            widx   <= '0;
            sum    <= '0;
            pass_q <= 1'b0;
            state  <= strap_q ? S_ISSUE : S_FINISH;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (wdone) begin
          sum <= sum + word[7:0] + word[15:8];
          if (widx == IW'(NWORDS - 1)) state <= S_CHECK;
          else begin
            widx  <= widx + 1'b1;
            state <= S_ISSUE;
          end
        end
        S_CHECK: begin
          pass_q <= (sum == 8'hFF);
          state  <= (sum == 8'hFF) ? S_COMMIT : S_FINISH;
        end
        S_COMMIT: if (commit_done) state <= S_FINISH;
        S_FINISH: begin
          state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
          cfg_valid <= pass_q; reload_bit <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_sel <= 1'b0; acc_stop <= 1'b0; acc_rdy <= 1'b0;
    end else begin
      acc_sel  <= acc_req;
      acc_stop <= acc_req && busy;
      acc_rdy  <= acc_req && !busy;
    end
  end

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
  // R8
  retry_shape_chk: assert property (@(posedge clk) disable iff (rst)
    acc_stop |-> acc_sel && !acc_rdy);
  // R8
  retry_busy_chk: assert property (@(posedge clk) disable iff (rst)
    acc_req && busy |=> acc_stop);
  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(cfg_valid));
  // R1
  absent_chk: assert property (@(posedge clk) disable iff (rst)
    done && !strap_q |-> !cfg_valid && !reload_bit);
endmodule

// File: tb/sim_eeprom_cfg_loader.sv
module sim_eeprom_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int SDLY = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ee_sk_sense = 1'b1;
  logic ee_do = 1'b0;
  logic reload_req = 1'b0;
  logic acc_req = 1'b0;
  logic [5:0] rd_addr = '0;
  logic ee_cs, ee_sk, ee_di, reload_bit, cfg_valid, busy, done;
  logic acc_sel, acc_stop, acc_rdy;
  logic [7:0] rd_data;

  eeprom_cfg_loader #(.HALF_DIV(HALF), .START_DLY(SDLY)) u0 (
    .clk(clk), .rst(rst), .ee_sk_sense(ee_sk_sense), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .reload_req(reload_req),
    .reload_bit(reload_bit), .cfg_valid(cfg_valid), .busy(busy), .done(done),
    .acc_req(acc_req), .acc_sel(acc_sel), .acc_stop(acc_stop), .acc_rdy(acc_rdy),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  // EEPROM image and expected values
  logic [15:0] img [18];
  bit img_good;

  task automatic mk_img(input int seed, input bit good);
    logic [7:0] s = 8'h00;
    for (int w = 0; w < 18; w++) begin
      img[w] = 16'(w * 16'h0907 + seed * 16'h1235);
      s = s + img[w][7:0];
      if (w != 17) s = s + img[w][15:8];
    end
    img[17][15:8] = 8'hFF - s;
    if (!good) img[17][15:8] = img[17][15:8] + 8'h01;
    img_good = good;
  endtask

  function automatic logic [7:0] img_byte(input int a);
    return a[0] ? img[a / 2][15:8] : img[a / 2][7:0];
  endfunction

  // scoreboard: expected word addresses, popped by the EEPROM monitor
  int exp_q [$];
  task automatic push_frames();
    for (int w = 0; w < 18; w++) exp_q.push_back(w);
  endtask

  int rc = 0;
  int cs_rises = 0;
  int last_cs_fall = -1;
  int sk_rise = 0;
  logic [8:0] cmdr = '0;
  logic [15:0] cur = '0;
  int e_addr = 0;

  always @(posedge ee_cs) begin
    rc = 0;
    cs_rises++;
    if (last_cs_fall >= 0) chk(cyc - last_cs_fall >= 2 * HALF, "R3 cs gap", cyc - last_cs_fall, 2 * HALF);
  end
  always @(negedge ee_cs) last_cs_fall = cyc;

  always @(posedge ee_sk) begin
    sk_rise = cyc;
    if (ee_cs) begin
      if (rc < 9) cmdr = {cmdr[7:0], ee_di};
      rc++;
      if (rc == 9) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected frame", cmdr, 0);
        else begin
          e_addr = exp_q.pop_front();
          chk(cmdr == {3'b110, 6'(e_addr)}, "R2 frame", cmdr, {3'b110, 6'(e_addr)});
        end
        cur = img[cmdr[5:0]];
      end
    end
  end

  always @(negedge ee_sk) begin
    chk(cyc - sk_rise == HALF, "R3 sk phase", cyc - sk_rise, HALF);
    if (ee_cs && rc >= 9 && rc < 25) ee_do = cur[15 - (rc - 9)];
  end

  task automatic rd_byte(input int a, output logic [7:0] d);
    @(negedge clk) rd_addr = 6'(a);
    @(negedge clk) d = rd_data;
  endtask

  task automatic wait_done();
    int n = 0;
    while (n < 30000) begin
      @(negedge clk);
      if (done) return;
      n++;
    end
    chk(1'b0, "R9 done timeout", 0, 1);
  endtask

  task automatic check_all(input string rq, input bit cfg_loaded);
    logic [7:0] d;
    for (int a = 0; a < 36; a++) begin
      rd_byte(a, d);
      if (a < 16 || cfg_loaded) chk(d == img_byte(a), rq, d, img_byte(a));
      else chk(d == (8'(a) ^ 8'hC3), rq, d, 8'(a) ^ 8'hC3);
    end
  endtask

  initial begin
    logic [7:0] d;
    int n;
    // power-up with EEPROM present, good image
    mk_img(1, 1'b1);
    push_frames();
    repeat (4) @(negedge clk);
    chk(busy && reload_bit && !cfg_valid && !done && !ee_cs, "R10 reset state",
        {busy, reload_bit, cfg_valid, done, ee_cs}, 5'b11000);
    rst = 1'b0;
    n = 0;
    while (!ee_cs && n < 1000) begin @(negedge clk); n++; end
    chk(n >= SDLY, "R10 start delay", n, SDLY);
    acc_req = 1'b1;
    @(negedge clk) acc_req = 1'b0;
    chk(acc_sel && acc_stop && !acc_rdy, "R8 retry while busy",
        {acc_sel, acc_stop, acc_rdy}, 3'b110);
    rd_byte(16, d);
    chk(d == 8'hD3, "R6 default during load", d, 8'hD3);
    wait_done();
    chk(!busy && cfg_valid && !reload_bit, "R9 done state", {busy, cfg_valid, reload_bit}, 3'b010);
    chk(exp_q.size() == 0, "R2 all words read", exp_q.size(), 0);
    acc_req = 1'b1;
    @(negedge clk) acc_req = 1'b0;
    chk(!done, "R9 pulse width", done, 0);
    chk(acc_sel && !acc_stop && acc_rdy, "R8 claim when idle", {acc_sel, acc_stop, acc_rdy}, 3'b101);
    @(negedge clk);
    chk(!acc_sel && !acc_stop && !acc_rdy, "R8 no request", {acc_sel, acc_stop, acc_rdy}, 3'b000);
    check_all("R4 readback", 1'b1);

    // reload with a bad checksum
    mk_img(2, 1'b0);
    push_frames();
    reload_req = 1'b1;
    @(negedge clk) reload_req = 1'b0;
    chk(reload_bit && busy, "R7 reload start", {reload_bit, busy}, 2'b11);
    repeat (3) @(negedge clk);
    reload_req = 1'b1;
    @(negedge clk) reload_req = 1'b0;
    rd_byte(20, d);
    begin
      logic [7:0] old;
      old = 8'(20 * 16'h0907 / 1);
      old = 8'(16'(10 * 16'h0907 + 1 * 16'h1235));
      chk(d == old, "R6 old value held", d, old);
    end
    wait_done();
    chk(!cfg_valid && !reload_bit, "R5 invalid after bad sum", {cfg_valid, reload_bit}, 2'b00);
    repeat (5) @(negedge clk);
    chk(!busy, "R7 request during load ignored", busy, 0);
    chk(exp_q.size() == 0, "R2 all words read", exp_q.size(), 0);
    check_all("R5 readback", 1'b0);

    // good reload, then a new reload and an access in the done cycle
    mk_img(3, 1'b1);
    push_frames();
    reload_req = 1'b1;
    @(negedge clk) reload_req = 1'b0;
    wait_done();
    chk(cfg_valid, "R4 valid after reload", cfg_valid, 1);
    push_frames();
    reload_req = 1'b1;
    acc_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0;
    acc_req = 1'b0;
    chk(acc_sel && acc_rdy && !acc_stop, "R8 access in done cycle", {acc_sel, acc_stop, acc_rdy}, 3'b101);
    chk(busy && reload_bit, "R7 reload in done cycle", {busy, reload_bit}, 2'b11);
    wait_done();
    chk(cfg_valid && exp_q.size() == 0, "R4 back-to-back load", {cfg_valid, 8'(exp_q.size())}, 9'h100);
    rd_byte(30, d);
    chk(d == img_byte(30), "R4 byte 30", d, img_byte(30));

    // no EEPROM fitted
    rst = 1'b1;
    ee_sk_sense = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = cs_rises;
    wait_done();
    chk(!cfg_valid && !reload_bit, "R1 absent flags", {cfg_valid, reload_bit}, 2'b00);
    chk(cs_rises == n, "R1 no select activity", cs_rises - n, 0);
    rd_byte(25, d);
    chk(d == (8'd25 ^ 8'hC3), "R1 default config", d, 8'd25 ^ 8'hC3);
    finish_run();
  end
endmodule